// File: doc/BRIEF.md
# HDLC Receive Message FIFO

This block is a 64-location byte queue between an HDLC receive deframer and a processor that polls it. When a message opens, one location is set aside for a status byte. The message's data bytes follow that location. When the message closes, the status byte is rewritten in place with an end type and a data byte count. The processor reads one byte per strobe. A flag tells it whether the byte waiting at the head is a status byte or a data byte, so it can split the stream into messages without any side channel.

A programmable threshold raises a near-full flag. When a data byte brings the fill level up to that threshold, the current message is closed as partial with its count so far, and the rest of that message is thrown away. If a message fills the queue completely, it is closed as partial with a count of zero, and any message that opens while the queue is full is lost. Messages that were already complete stay readable. In unformatted mode the bytes are queued raw, with no status bytes.

Top module: `hdlc_rx_msg_fifo`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_full, near_full and next_is_status are 0, rd_data is 0, and msg_active is 0 while unformatted is 0.
- R2: Bytes come out in the order they were stored, each message's status byte before its data. next_is_status is 1 exactly when the queue is not empty and the head location holds a status byte.
- R3: A status byte carries the end type in bits [7:6] (00 open, 01 good, 10 error, 11 partial) and the number of stored data bytes in bits [5:0]. A pulse on rx_end rewrites the status byte of an open message to 01 with its count.
- R4: A pulse on rx_abort rewrites the status byte of an open message to 10 with its count.
- R5: In HDLC mode, msg_active rises on the cycle after rx_start and falls on the cycle after rx_end or rx_abort. While unformatted is 1, msg_active is 1 throughout.
- R6: A read strobe while fifo_empty is 1 returns 0 on rd_data and moves no pointer, so later traffic is read back intact.
- R7: near_full is 1 while the fill level, counting status and data locations, is at or above nf_thresh. It clears only when reads bring the level below the threshold.
- R8: When a data byte brings the level up to nf_thresh, the message's status byte becomes 11 with the count including that byte. The message's later bytes and its end pulse are ignored.
- R9: fifo_full is 1 when all 64 locations are occupied. A message whose write fills the last location gets status 11 with count 0, and its later bytes are dropped. A message that opens while the queue is full stores nothing.
- R10: Complete messages stored before an overflow read back unchanged, and fifo_full clears on the first read after the queue filled.
- R11: While unformatted is 1, each rx_valid byte is stored raw with no status byte, and next_is_status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unformatted | input | 1 | 1 selects raw byte mode with no message framing |
| nf_thresh | input | 6 | Near-full fill level |
| rx_valid | input | 1 | rx_byte carries a received byte |
| rx_byte | input | 8 | Received byte |
| rx_start | input | 1 | Pulse: a message opens |
| rx_end | input | 1 | Pulse: the message closed well |
| rx_abort | input | 1 | Pulse: the message was aborted or ended in error |
| rd_en | input | 1 | Read strobe; pops the head byte |
| rd_data | output | 8 | Head byte, or 0 when empty |
| fifo_empty | output | 1 | No locations are occupied |
| fifo_full | output | 1 | All 64 locations are occupied |
| near_full | output | 1 | Level at or above nf_thresh |
| next_is_status | output | 1 | The head byte is a status byte |
| msg_active | output | 1 | A message is being received |

## Verification
The bench fills the queue to exactly 64 locations with a good message, then a message cut short by near-full, then a message that overflows. A design that patched the wrong location, or that reported a nonzero count for the overflowed message, is caught when the reads are compared against the scoreboard. A read strobe on an empty queue is followed by a new message. A design that moved a pointer on that strobe would return shifted bytes. At every read the bench compares near_full and fifo_full against the level it expects, so a flag that clears early or sticks is seen on the exact read where it goes wrong. A raw-mode burst checks that no status byte is inserted and that the status flag stays low.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    END_OPEN = 2'b00,
    END_GOOD = 2'b01,
    END_ERR  = 2'b10,
    END_PART = 2'b11
  } end_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_STORE = 2'd1,
    SQ_DROP  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_tag,
  input  logic [7:0]    wr_byte,
  input  logic          pt_en,
  input  logic [AW-1:0] pt_addr,
  input  logic [7:0]    pt_byte,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_tag,
  output logic [7:0]    rd_byte
);
  // bit 8 marks a status location
  logic [8:0] mem [DEPTH];
  logic       pt_ok;

  assign pt_ok = pt_en && !(wr_en && (wr_addr == pt_addr));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_tag, wr_byte};
    if (pt_ok) mem[pt_addr] <= {1'b1, pt_byte};
  end

  assign rd_tag  = mem[rd_addr][8];
  assign rd_byte = mem[rd_addr][7:0];
endmodule

// File: rtl/hrf_level.sv
module hrf_level #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop_req,
  input  logic [AW-1:0] thr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          empty,
  output logic          full,
  output logic          near_full,
  output logic          nf_hit,
  output logic          full_hit
);
  localparam logic [CW-1:0] DEPTH_L = CW'(DEPTH);
  localparam logic [CW-1:0] TOP_L   = CW'(DEPTH - 1);

  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] lvl_q, lvl_d, thr_ext;
  logic          nf_q, nf_d, pop;

  always_comb begin
    thr_ext  = CW'(thr);
    empty    = (lvl_q == '0);
    full     = (lvl_q == DEPTH_L);
    pop      = pop_req && !empty;
    wr_d     = push ? wr_q + AW'(1) : wr_q;
    rd_d     = pop  ? rd_q + AW'(1) : rd_q;
    lvl_d    = lvl_q + CW'(push) - CW'(pop);
    nf_d     = (lvl_d >= thr_ext);
    nf_hit   = nf_d && (lvl_q < thr_ext);
    full_hit = push && !pop && (lvl_q == TOP_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      nf_q  <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      nf_q  <= nf_d;
    end
  end

  assign wr_ptr    = wr_q;
  assign rd_ptr    = rd_q;
  assign near_full = nf_q;

  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> (rd_q == $past(rd_q)));
  p_nf_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nf_q) && $stable(thr)) |-> $past(pop));
  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= DEPTH_L);
endmodule

// File: rtl/hrf_seq.sv
module hrf_seq
  import hrf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unformatted,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_start,
  input  logic          rx_end,
  input  logic          rx_abort,
  input  logic          full,
  input  logic          nf_hit,
  input  logic          full_hit,
  input  logic [AW-1:0] wr_ptr,
  output logic          push,
  output logic          push_tag,
  output logic [7:0]    push_byte,
  output logic          patch_en,
  output logic [AW-1:0] patch_addr,
  output logic [7:0]    patch_byte,
  output logic          in_msg
);
  seq_st_e          st_q, st_d;
  logic [AW-1:0]    hdr_q, hdr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    st_d       = st_q;
    hdr_d      = hdr_q;
    cnt_d      = cnt_q;
    push       = 1'b0;
    push_tag   = 1'b0;
    push_byte  = rx_byte;
    patch_en   = 1'b0;
    patch_byte = '0;
    if (unformatted) begin
      st_d = SQ_IDLE;
      push = rx_valid && !full;
    end else if (rx_abort) begin
      if (st_q == SQ_STORE) begin
        patch_en   = 1'b1;
        patch_byte = {END_ERR, cnt_q};
      end
      st_d = SQ_IDLE;
    end else if (rx_end) begin
      if (st_q == SQ_STORE) begin
        patch_en   = 1'b1;
        patch_byte = {END_GOOD, cnt_q};
      end
      st_d = SQ_IDLE;
    end else if (rx_start && (st_q == SQ_IDLE)) begin
      if (full) begin
        st_d = SQ_DROP;
      end else begin
        push     = 1'b1;
        push_tag = 1'b1;
        hdr_d    = wr_ptr;
        cnt_d    = '0;
        if (full_hit) begin
          push_byte = {END_PART, CNT_W'(0)};
          st_d      = SQ_DROP;
        end else begin
          push_byte = {END_OPEN, CNT_W'(0)};
          st_d      = SQ_STORE;
        end
      end
    end else if (rx_valid && (st_q == SQ_STORE) && !full) begin
      push  = 1'b1;
      cnt_d = cnt_inc;
      if (full_hit) begin
        patch_en   = 1'b1;
        patch_byte = {END_PART, CNT_W'(0)};
        st_d       = SQ_DROP;
      end else if (nf_hit) begin
        patch_en   = 1'b1;
        patch_byte = {END_PART, cnt_inc};
        st_d       = SQ_DROP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      hdr_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      hdr_q <= hdr_d;
      cnt_q <= cnt_d;
    end
  end

  assign patch_addr = hdr_q;
  assign in_msg     = (st_q != SQ_IDLE);

  p_unfmt_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (unformatted && push) |-> !push_tag);
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!unformatted && (st_q == SQ_DROP)) |-> !push);
  p_patch_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (patch_en && push) |-> (patch_addr != wr_ptr));
endmodule

// File: rtl/hdlc_rx_msg_fifo.sv
module hdlc_rx_msg_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unformatted,
  input  logic [AW-1:0] nf_thresh,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_start,
  input  logic          rx_end,
  input  logic          rx_abort,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          near_full,
  output logic          next_is_status,
  output logic          msg_active
);
  logic [1:0]    rst_sync;
  logic          rst_i;
  logic          push, push_tag, patch_en, nf_hit, full_hit, in_msg, rd_tag;
  logic [7:0]    push_byte, patch_byte, rd_byte;
  logic [AW-1:0] wr_ptr, rd_ptr, patch_addr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  hrf_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_i), .push(push), .pop_req(rd_en), .thr(nf_thresh),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .empty(fifo_empty), .full(fifo_full),
    .near_full(near_full), .nf_hit(nf_hit), .full_hit(full_hit)
  );

  hrf_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_i), .unformatted(unformatted), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_start(rx_start), .rx_end(rx_end), .rx_abort(rx_abort),
    .full(fifo_full), .nf_hit(nf_hit), .full_hit(full_hit), .wr_ptr(wr_ptr),
    .push(push), .push_tag(push_tag), .push_byte(push_byte), .patch_en(patch_en),
    .patch_addr(patch_addr), .patch_byte(patch_byte), .in_msg(in_msg)
  );

  hrf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(push), .wr_addr(wr_ptr), .wr_tag(push_tag), .wr_byte(push_byte),
    .pt_en(patch_en), .pt_addr(patch_addr), .pt_byte(patch_byte),
    .rd_addr(rd_ptr), .rd_tag(rd_tag), .rd_byte(rd_byte)
  );

  assign rd_data        = fifo_empty ? 8'h00 : rd_byte;
  assign next_is_status = !fifo_empty && rd_tag;
  assign msg_active     = unformatted || in_msg;

  p_active_start_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (!unformatted && rx_start && !msg_active && !rx_end && !rx_abort) |=> msg_active);
endmodule

// File: tb/test_hdlc_rx_msg_fifo.sv
module test_hdlc_rx_msg_fifo;
  logic       clk = 1'b0;
  logic       rst_n, unformatted, rx_valid, rx_start, rx_end, rx_abort, rd_en;
  logic [5:0] nf_thresh;
  logic [7:0] rx_byte, rd_data;
  logic       fifo_empty, fifo_full, near_full, next_is_status, msg_active;

  int n_checks = 0, n_errors = 0;
  logic [8:0] sb[$];      // expected contents: {is_status, byte}
  int  hdr_idx;
  bit  m_store, m_drop;
  int  m_cnt;

  always #5 clk = ~clk;

  hdlc_rx_msg_fifo i_hdlc_rx_msg_fifo (
    .clk(clk), .rst_n(rst_n), .unformatted(unformatted), .nf_thresh(nf_thresh),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_start(rx_start), .rx_end(rx_end),
    .rx_abort(rx_abort), .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .near_full(near_full), .next_is_status(next_is_status),
    .msg_active(msg_active)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sb_patch(logic [7:0] v);
    sb[hdr_idx] = {1'b1, v};
  endtask

  task automatic start_msg();
    rx_start = 1'b1; step(); rx_start = 1'b0;
    if (sb.size() == 64) begin
      m_drop = 1;
    end else begin
      hdr_idx = sb.size();
      if (sb.size() == 63) begin sb.push_back({1'b1, 8'hC0}); m_drop = 1; end
      else begin sb.push_back(9'h100); m_store = 1; m_cnt = 0; end
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; step(); rx_valid = 1'b0;
    if (unformatted) begin
      if (sb.size() < 64) sb.push_back({1'b0, b});
    end else if (m_store && sb.size() < 64) begin
      sb.push_back({1'b0, b});
      m_cnt++;
      if (sb.size() == 64) begin sb_patch(8'hC0); m_store = 0; m_drop = 1; end
      else if (sb.size() == int'(nf_thresh)) begin
        sb_patch({2'b11, 6'(m_cnt)}); m_store = 0; m_drop = 1;
      end
    end
  endtask

  task automatic close_msg(bit good);
    if (good) rx_end = 1'b1; else rx_abort = 1'b1;
    step(); rx_end = 1'b0; rx_abort = 1'b0;
    if (m_store) sb_patch({good ? 2'b01 : 2'b10, 6'(m_cnt)});
    m_store = 0; m_drop = 0;
  endtask

  task automatic message(int n, bit good, logic [7:0] seed);
    start_msg();
    for (int i = 0; i < n; i++) send_byte(seed + 8'(i));
    close_msg(good);
  endtask

  // monitor: pop each expected item and compare with what the design shows
  task automatic drain(string req);
    while (sb.size() > 0) begin
      check("R7", near_full, sb.size() >= int'(nf_thresh), {req, " near_full vs level"});
      check("R9", fifo_full, sb.size() == 64, {req, " fifo_full vs level"});
      check("R2", next_is_status, sb[0][8], {req, " next_is_status"});
      check(req, rd_data, sb[0][7:0], "read byte");
      rd_en = 1'b1; step(); rd_en = 1'b0;
      void'(sb.pop_front());
      hdr_idx--;
    end
    check("R2", fifo_empty, 1, {req, " empty after drain"});
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; unformatted = 1'b0; nf_thresh = 6'd40; rx_valid = 1'b0;
    rx_byte = 8'h00; rx_start = 1'b0; rx_end = 1'b0; rx_abort = 1'b0; rd_en = 1'b0;
    m_store = 0; m_drop = 0; m_cnt = 0; hdr_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    check("R1", fifo_empty, 1, "empty");
    check("R1", fifo_full, 0, "full");
    check("R1", near_full, 0, "near_full");
    check("R1", next_is_status, 0, "next_is_status");
    check("R1", rd_data, 0, "rd_data");
    check("R1", msg_active, 0, "msg_active");

    // R3 good close, R4 abort, R5 activity flag
    start_msg();
    check("R5", msg_active, 1, "active after start");
    for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i));
    close_msg(1);
    check("R5", msg_active, 0, "idle after end");
    message(3, 0, 8'h50);
    check("R5", msg_active, 0, "idle after abort");
    check("R2", next_is_status, 1, "status at head");
    drain("R3");

    // R6 read of an empty queue
    rd_en = 1'b1; step(); rd_en = 1'b0;
    check("R6", rd_data, 0, "empty read data");
    check("R6", fifo_empty, 1, "still empty");
    message(2, 1, 8'h33);
    drain("R6");

    // R7 / R8 near-full cut
    nf_thresh = 6'd10;
    message(15, 1, 8'h10);
    check("R7", near_full, 1, "near_full set");
    check("R8", msg_active, 0, "idle after end of cut message");
    drain("R8");
    check("R7", near_full, 0, "near_full clear after reads");

    // R9 / R10 overflow
    nf_thresh = 6'd20;
    message(3, 1, 8'h70);
    message(25, 1, 8'h80);
    start_msg();
    for (int i = 0; i < 50; i++) send_byte(8'hC0 ^ 8'(i));
    check("R9", fifo_full, 1, "full after overflow");
    close_msg(1);
    message(3, 1, 8'hE0);
    check("R9", fifo_full, 1, "still full after lost message");
    drain("R10");

    // R11 unformatted raw bytes
    unformatted = 1'b1;
    step();
    check("R11", msg_active, 1, "active in raw mode");
    for (int i = 0; i < 4; i++) send_byte(8'h5A + 8'(i));
    check("R11", next_is_status, 0, "no status in raw mode");
    drain("R11");
    unformatted = 1'b0;
    step();
    check("R5", msg_active, 0, "idle leaving raw mode");

    report();
  end
endmodule